// File: doc/BRIEF.md
# Iterative Word-Rotation Block Cipher Engine

This block encrypts one 4w-bit block at a time with a data-dependent-rotation cipher built from four w-bit words. Each block goes through three stages: a whitening step that adds two round keys, a fixed number of identical rounds, and a final key addition. The engine computes one round per clock cycle in a single round stage that is used again on every cycle. Each round uses two quadratic mixing terms, a multiply of a word by twice itself plus one. The results drive variable rotations of the other two words, and each round ends with a cyclic shift of the four words.

The round keys are supplied in advance through a write port of one word per cycle and stored in two single-port banks. One bank holds the even-indexed keys and the other the odd-indexed keys, so every step of an encryption reads exactly one key from each bank. Writing a block starts an encryption at once. A fixed number of cycles later the ciphertext appears on a registered output together with a one-cycle completion pulse. The output keeps that ciphertext until the next encryption completes.

Top module: `wordrot_cipher`

## Requirements
- R1: After reset, `blk_o` is all zeros and `done_o` is low. `blk_o` stays zero until the first encryption completes.
- R2: A key write with index `key_idx_i` = j stores key S[j]. Even j goes to the even bank and odd j goes to the odd bank, both at address j>>1. Keys S[0] to S[2r+3] are all addressable.
- R3: The block word mapping is A=`blk_i[4w-1:3w]`, B=`blk_i[3w-1:2w]`, C=`blk_i[2w-1:w]`, D=`blk_i[w-1:0]`. Whitening adds S[0] to B and S[1] to D. Round i (1..r) forms T=rotl(B*(2B+1),k) and U=rotl(D*(2D+1),k), then sets A'=rotl(A^T,U)+S[2i] and C'=rotl(C^U,T)+S[2i+1], and then (A,B,C,D)=(B,C',D,A'). The final step adds S[2r+2] to A and S[2r+3] to C. `blk_o`={A,B,C,D} with A in the top word. All arithmetic is modulo 2^w.
- R4: A variable rotation uses only the low k=log2(w) bits of the word that gives the amount.
- R5: `done_o` goes high exactly r+2 rising edges after the edge that accepts `blk_we_i`.
- R6: `done_o` is high for exactly one cycle per encryption, and `blk_o` takes the new ciphertext on the same edge that raises `done_o`.
- R7: `blk_o` does not change except on an edge that raises `done_o`.
- R8: A `blk_we_i` while an encryption is running is ignored. The running encryption finishes with the first block's ciphertext, and no further `done_o` follows.
- R9: A key write during an encryption, or in the same cycle as an accepted `blk_we_i`, is ignored. The stored keys are unchanged.
- R10: A `blk_we_i` in the cycle where `done_o` is high is accepted and starts a new encryption with the full r+2 latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| key_we_i | input | 1 | Round key write strobe |
| key_idx_i | input | KIDX_W | Round key index j |
| key_data_i | input | WORD_W | Round key value S[j] |
| blk_we_i | input | 1 | Block load strobe; starts encryption |
| blk_i | input | 4*WORD_W | Plaintext block |
| done_o | output | 1 | One-cycle completion pulse |
| blk_o | output | 4*WORD_W | Last ciphertext, zero before the first |

## Verification
Ciphertexts are compared against a bench model of the cipher under three key sets: all-zero keys, random keys, and keys rewritten one at a time. The all-zero set isolates the round mixing from the key additions. The single rewrites of one even and one odd key show whether each index reaches the correct bank and address. The random blocks cover the general rotate and multiply paths. The blocks that are all zeros, all ones and 0x80 in every byte drive the mixing terms to extremes where rotation amounts wrap, which separates a low-bit rotate from a full-width one. Timed scenarios measure the latency, place a second block load in the middle of a run, place key writes during a run and in the same cycle as a load, and start a new block in the completion cycle. Together they tell a correct controller apart from one that restarts, drops a back-to-back block, or lets a key write disturb the banks.

// File: rtl/wrc_pkg.sv
package wrc_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_WHITEN = 2'd1,
    PH_ROUND  = 2'd2,
    PH_FINAL  = 2'd3
  } phase_e;
endpackage

// File: rtl/wrc_rotl.sv
// Left rotation of a word by a run-time amount taken from log2(W) bits.
module wrc_rotl #(
  parameter int W  = 8,
  parameter int SW = $clog2(W)
) (
  input  logic [W-1:0]  x,
  input  logic [SW-1:0] amt,
  output logic [W-1:0]  y
);
  logic [2*W-1:0] dbl;

  always_comb begin
    dbl = {x, x} << amt;
    y   = dbl[2*W-1:W];
  end
endmodule

// File: rtl/wrc_key_bank.sv
// Single-port key store with synchronous read, shaped for block RAM inference.
module wrc_key_bank #(
  parameter int W     = 8,
  parameter int DEPTH = 14,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] addr;

  // one port: a write takes the port, otherwise the read address does
  assign addr = we ? waddr : raddr;

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/wrc_round.sv
// One full cipher round, combinational, including the word permutation.
module wrc_round #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] c,
  input  logic [W-1:0] d,
  input  logic [W-1:0] key_even,
  input  logic [W-1:0] key_odd,
  output logic [W-1:0] na,
  output logic [W-1:0] nb,
  output logic [W-1:0] nc,
  output logic [W-1:0] nd
);
  localparam int SW = $clog2(W);
  localparam logic [SW-1:0] K_AMT = SW'(SW);

  logic [W-1:0] sq_b, sq_d, t_w, u_w, ax, cx, ar, cr;

  always_comb begin
    sq_b = b * {b[W-2:0], 1'b1};
    sq_d = d * {d[W-2:0], 1'b1};
  end

  wrc_rotl #(.W(W)) u_rot_t (.x(sq_b), .amt(K_AMT), .y(t_w));
  wrc_rotl #(.W(W)) u_rot_u (.x(sq_d), .amt(K_AMT), .y(u_w));

  assign ax = a ^ t_w;
  assign cx = c ^ u_w;

  // amounts come from the low log2(W) bits only
  wrc_rotl #(.W(W)) u_rot_a (.x(ax), .amt(u_w[SW-1:0]), .y(ar));
  wrc_rotl #(.W(W)) u_rot_c (.x(cx), .amt(t_w[SW-1:0]), .y(cr));

  always_comb begin
    na = b;
    nb = cr + key_odd;
    nc = d;
    nd = ar + key_even;
  end
endmodule

// File: rtl/wrc_ctrl.sv
// Phase sequencer: idle, whitening, r rounds, final key addition.
module wrc_ctrl
  import wrc_pkg::*;
#(
  parameter int ROUNDS = 12,
  parameter int AW     = $clog2(ROUNDS + 2)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          blk_we,
  output phase_e        phase_o,
  output logic [AW-1:0] rd_addr_o,
  output logic          done_o
);
  localparam int LW = AW + 1;

  phase_e        phase_q;
  logic [AW-1:0] step_q;
  logic [LW-1:0] lat_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      step_q  <= '0;
      done_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (phase_q)
        PH_IDLE:   if (blk_we) phase_q <= PH_WHITEN;
        PH_WHITEN: begin
          phase_q <= PH_ROUND;
          step_q  <= AW'(1);
        end
        PH_ROUND:  begin
          if (step_q == AW'(ROUNDS)) phase_q <= PH_FINAL;
          else                       step_q  <= step_q + 1'b1;
        end
        default: begin
          phase_q <= PH_IDLE;
          done_o  <= 1'b1;
        end
      endcase
    end
  end

  // address for the key pair needed in the following cycle
  always_comb begin
    case (phase_q)
      PH_WHITEN: rd_addr_o = AW'(1);
      PH_ROUND:  rd_addr_o = step_q + 1'b1;
      default:   rd_addr_o = '0;
    endcase
  end

  assign phase_o = phase_q;

  // cycle count since the accepting edge, for the latency property
  always_ff @(posedge clk) begin
    if (rst)                   lat_cnt <= '0;
    else if (phase_q == PH_IDLE) lat_cnt <= '0;
    else                       lat_cnt <= lat_cnt + 1'b1;
  end

  assert_latency_R5: assert property (@(posedge clk) disable iff (rst)
    done_o |-> lat_cnt == LW'(ROUNDS + 2));

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  assert_no_restart_R8: assert property (@(posedge clk) disable iff (rst)
    (phase_q != PH_IDLE && blk_we) |=> phase_q != PH_WHITEN);

  assert_done_ready_R10: assert property (@(posedge clk) disable iff (rst)
    done_o |-> phase_q == PH_IDLE);
endmodule

// File: rtl/wordrot_cipher.sv
module wordrot_cipher
  import wrc_pkg::*;
#(
  parameter int WORD_W = 8,
  parameter int ROUNDS = 12,
  parameter int KIDX_W = $clog2(2 * ROUNDS + 4)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                key_we_i,
  input  logic [KIDX_W-1:0]   key_idx_i,
  input  logic [WORD_W-1:0]   key_data_i,
  input  logic                blk_we_i,
  input  logic [4*WORD_W-1:0] blk_i,
  output logic                done_o,
  output logic [4*WORD_W-1:0] blk_o
);
  localparam int NKEYS = 2 * ROUNDS + 4;
  localparam int DEPTH = ROUNDS + 2;
  localparam int AW    = KIDX_W - 1;
  localparam int W     = WORD_W;

  phase_e        phase;
  logic [AW-1:0] rd_addr;
  logic          key_wr;
  logic [W-1:0]  bank_rd [2];
  logic [W-1:0]  wa, wb, wc, wd;
  logic [W-1:0]  ra, rb, rc, rd;

  // key port only owns the banks while idle and not starting
  assign key_wr = key_we_i && (phase == PH_IDLE) && !blk_we_i
                  && ({1'b0, key_idx_i} < (KIDX_W + 1)'(NKEYS));

  for (genvar p = 0; p < 2; p++) begin : g_bank
    wrc_key_bank #(.W(W), .DEPTH(DEPTH), .AW(AW)) u_bank (
      .clk   (clk),
      .we    (key_wr && (key_idx_i[0] == 1'(p))),
      .waddr (key_idx_i[KIDX_W-1:1]),
      .wdata (key_data_i),
      .raddr (rd_addr),
      .rdata (bank_rd[p])
    );
  end

  wrc_ctrl #(.ROUNDS(ROUNDS), .AW(AW)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .blk_we    (blk_we_i),
    .phase_o   (phase),
    .rd_addr_o (rd_addr),
    .done_o    (done_o)
  );

  wrc_round #(.W(W)) u_round (
    .a(wa), .b(wb), .c(wc), .d(wd),
    .key_even (bank_rd[0]),
    .key_odd  (bank_rd[1]),
    .na(ra), .nb(rb), .nc(rc), .nd(rd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wa    <= '0;
      wb    <= '0;
      wc    <= '0;
      wd    <= '0;
      blk_o <= '0;
    end else begin
      case (phase)
        PH_IDLE: if (blk_we_i) begin
          wa <= blk_i[3*W +: W];
          wb <= blk_i[2*W +: W];
          wc <= blk_i[W +: W];
          wd <= blk_i[0 +: W];
        end
        PH_WHITEN: begin
          wb <= wb + bank_rd[0];
          wd <= wd + bank_rd[1];
        end
        PH_ROUND: begin
          wa <= ra;
          wb <= rb;
          wc <= rc;
          wd <= rd;
        end
        default: blk_o <= {wa + bank_rd[0], wb, wc + bank_rd[1], wd};
      endcase
    end
  end

  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> $stable(blk_o));

  assert_key_idle_R9: assert property (@(posedge clk) disable iff (rst)
    key_wr |=> phase == PH_IDLE);

  assert_first_zero_R1: assert property (@(posedge clk) disable iff (rst)
    ($past(blk_o) == '0 && !done_o) |-> blk_o == '0);
endmodule

// File: tb/wordrot_cipher_bench.sv
`timescale 1ns/1ps
module wordrot_cipher_bench;
  localparam int W  = 8;
  localparam int R  = 12;
  localparam int NK = 2 * R + 4;
  localparam int KW = $clog2(NK);
  localparam int K  = $clog2(W);
  localparam int BW = 4 * W;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          key_we = 1'b0;
  logic [KW-1:0] key_idx = '0;
  logic [W-1:0]  key_data = '0;
  logic          blk_we = 1'b0;
  logic [BW-1:0] blk_in = '0;
  logic          done_o;
  logic [BW-1:0] blk_o;

  int checks = 0;
  int fails  = 0;
  logic [W-1:0] kmem [NK];

  always #2.5 clk = ~clk;

  wordrot_cipher #(.WORD_W(W), .ROUNDS(R)) u_wordrot_cipher (
    .clk(clk), .rst(rst),
    .key_we_i(key_we), .key_idx_i(key_idx), .key_data_i(key_data),
    .blk_we_i(blk_we), .blk_i(blk_in),
    .done_o(done_o), .blk_o(blk_o)
  );

  function automatic logic [W-1:0] rotl(input logic [W-1:0] x, input int amt);
    int s;
    s = amt % W;
    return W'((x << s) | (x >> (W - s)));
  endfunction

  function automatic logic [BW-1:0] ref_enc(input logic [BW-1:0] blk);
    logic [W-1:0] a, b, c, d, t, u, na, nc;
    a = blk[3*W +: W]; b = blk[2*W +: W]; c = blk[W +: W]; d = blk[0 +: W];
    b = b + kmem[0];
    d = d + kmem[1];
    for (int i = 1; i <= R; i++) begin
      t  = rotl(W'(b * (2 * b + 1)), K);
      u  = rotl(W'(d * (2 * d + 1)), K);
      na = rotl(a ^ t, int'(u)) + kmem[2*i];
      nc = rotl(c ^ u, int'(t)) + kmem[2*i+1];
      a = b; b = nc; c = d; d = na;
    end
    a = a + kmem[2*R+2];
    c = c + kmem[2*R+3];
    return {a, b, c, d};
  endfunction

  task automatic check(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  task automatic write_key(input int idx, input logic [W-1:0] val);
    @(negedge clk);
    key_we = 1'b1; key_idx = KW'(idx); key_data = val;
    kmem[idx] = val;
    @(negedge clk);
    key_we = 1'b0;
  endtask

  // returns at the negedge where done_o is first seen high
  task automatic run_block(input logic [BW-1:0] blk, output int lat);
    @(negedge clk);
    blk_we = 1'b1; blk_in = blk;
    @(negedge clk);
    blk_we = 1'b0;
    lat = 0;
    while (!done_o && lat < 200) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic enc_check(input logic [BW-1:0] blk, input string tag);
    int lat;
    logic [BW-1:0] exp;
    exp = ref_enc(blk);
    run_block(blk, lat);
    check(lat == R + 2, "R5 latency", 64'(lat), 64'(R + 2));
    check(blk_o == exp, tag, 64'(blk_o), 64'(exp));
    @(negedge clk);
    check(done_o == 1'b0, "R6 single-cycle done", 64'(done_o), 64'd0);
    check(blk_o == exp, "R7 output held", 64'(blk_o), 64'(exp));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired: run did not complete");
    summary();
    $finish;
  end

  initial begin
    int lat, extra;
    logic [BW-1:0] x, y, exp;
    logic [W-1:0] oldk;
    void'($urandom(32'h1234_abcd));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(blk_o == '0, "R1 reset output", 64'(blk_o), 64'd0);
    check(done_o == 1'b0, "R1 reset done", 64'(done_o), 64'd0);

    // all-zero keys
    for (int j = 0; j < NK; j++) write_key(j, '0);
    check(blk_o == '0, "R1 zero before first result", 64'(blk_o), 64'd0);
    enc_check(32'h0123_4567, "R3 zero keys");

    // random keys, random blocks
    for (int j = 0; j < NK; j++) write_key(j, W'($urandom));
    for (int n = 0; n < 20; n++) enc_check($urandom, "R3 random block");

    // directed extremes for the rotate amounts
    enc_check('0,            "R4 all-zero block");
    enc_check('1,            "R4 all-ones block");
    enc_check(32'h8080_8080, "R4 high-bit block");

    // single even and odd key rewrites
    write_key(6, W'($urandom));
    enc_check($urandom, "R2 even key rewrite");
    write_key(2 * R + 3, W'($urandom));
    enc_check($urandom, "R2 odd key rewrite");

    // load while busy is ignored
    x = $urandom; y = $urandom; exp = ref_enc(x);
    @(negedge clk);
    blk_we = 1'b1; blk_in = x;
    @(negedge clk);
    blk_we = 1'b0;
    lat = 0;
    while (!done_o && lat < 200) begin
      @(negedge clk);
      lat++;
      blk_we = (lat == 3);
      if (lat == 3) blk_in = y;
    end
    blk_we = 1'b0;
    check(lat == R + 2, "R8 latency unchanged", 64'(lat), 64'(R + 2));
    check(blk_o == exp, "R8 first block kept", 64'(blk_o), 64'(exp));
    extra = 0;
    repeat (R + 4) begin
      @(negedge clk);
      if (done_o) extra++;
    end
    check(extra == 0, "R8 no extra done", 64'(extra), 64'd0);
    check(blk_o == exp, "R8 output unchanged", 64'(blk_o), 64'(exp));

    // key write during a run is ignored
    x = $urandom; oldk = kmem[5];
    @(negedge clk);
    blk_we = 1'b1; blk_in = x;
    @(negedge clk);
    blk_we = 1'b0;
    @(negedge clk);
    key_we = 1'b1; key_idx = KW'(5); key_data = ~oldk;
    @(negedge clk);
    key_we = 1'b0;
    lat = 0;
    while (!done_o && lat < 200) begin @(negedge clk); lat++; end
    enc_check($urandom, "R9 key write during run ignored");

    // key write in the same cycle as a load is ignored
    x = $urandom; exp = ref_enc(x);
    @(negedge clk);
    blk_we = 1'b1; blk_in = x;
    key_we = 1'b1; key_idx = KW'(8); key_data = ~kmem[8];
    @(negedge clk);
    blk_we = 1'b0; key_we = 1'b0;
    lat = 0;
    while (!done_o && lat < 200) begin @(negedge clk); lat++; end
    check(blk_o == exp, "R9 same-cycle key write run", 64'(blk_o), 64'(exp));
    enc_check($urandom, "R9 same-cycle key write ignored");

    // back-to-back: load in the done cycle
    x = $urandom;
    run_block(x, lat);
    y = $urandom; exp = ref_enc(y);
    blk_we = 1'b1; blk_in = y;
    @(negedge clk);
    blk_we = 1'b0;
    lat = 0;
    while (!done_o && lat < 200) begin @(negedge clk); lat++; end
    check(lat == R + 2, "R10 back-to-back latency", 64'(lat), 64'(R + 2));
    check(blk_o == exp, "R10 back-to-back result", 64'(blk_o), 64'(exp));

    summary();
    $finish;
  end
endmodule